// File: doc/BRIEF.md
# Byte Lane Strobe Generator

This block turns one internal access request into the active-low control strobes of an external static memory. A request is a start pulse that comes with an address, a 4-bit byte-enable mask and a read/write flag. The configuration is sampled together with the request. It selects an 8-, 16- or 32-bit data bus. It also selects one of two lane schemes. In the per-lane scheme, each byte lane has its own write strobe and reads carry no lane information. In the select scheme, one common write enable is qualified by per-lane byte selects, and those selects also qualify reads.

Every access has the same shape. Chip select goes low for four cycles. The read strobe or write strobe is low in the middle two of those cycles, which gives one setup cycle, a two-cycle pulse and one hold cycle. A done pulse follows. If the configuration holds the reserved bus-width code, no access is started and an error pulse is raised instead.

Top module: `lane_strobe_gen`

## Requirements
- R1: After reset, and whenever reset is applied during an access, all strobes are high: cs_n, rd_n, we_n, every bit of wr_n and every bit of bs_n. In the same condition done, err and busy are low.
- R2: A start sampled while idle drives cs_n low for exactly four cycles, beginning the cycle after the start. The read or write strobe is low only in the 2nd and 3rd of those cycles. Outside the cs_n-low window no strobe is ever low.
- R3: done is high for exactly one cycle, the first cycle in which cs_n is high again. busy is high from the cycle after the start through the done cycle. A start that arrives while busy is high is ignored.
- R4: cfg_width encodes 00 as an 8-bit bus, 01 as 16-bit and 10 as 32-bit. The code 11 is reserved: a start with code 11 gives a single err pulse in the next cycle, and cs_n stays high, busy stays low and no strobe moves.
- R5: The active lane mask depends on the bus width. On a 32-bit bus, lane i follows be[i]. On a 16-bit bus, lane j (j = 0 or 1) follows be[2*addr[1]+j]. On an 8-bit bus, lane 0 follows be[addr[1:0]].
- R6: Per-lane scheme (cfg_byte_write=1), 16/32-bit bus, write: during the pulse wr_n[i] is low for each active lane. we_n and all bs_n stay high.
- R7: Per-lane scheme, 16/32-bit bus, read: rd_n is low during the pulse. wr_n, bs_n and we_n all stay high.
- R8: Select scheme (cfg_byte_write=0), 16/32-bit bus, write: we_n is low during the pulse. bs_n[i] is low for each active lane during the whole cs_n-low window. wr_n stays high.
- R9: Select scheme, 16/32-bit bus, read: rd_n is low during the pulse. bs_n[i] is low for each active lane during the whole cs_n-low window.
- R10: On an 8-bit bus the scheme input has no effect. A write pulses only we_n, and only if lane 0 is active. A read pulses only rd_n. wr_n and bs_n stay high.
- R11: On a 16-bit bus, wr_n[3:2] and bs_n[3:2] stay high for the whole access.
- R12: bus_addr carries the request address throughout the cs_n-low window. Changes to the request or configuration inputs during an access do not affect it.
- R13: A write with an empty active lane mask still runs the full chip-select cycle, but drives no write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle access request |
| req_addr | input | ADDR_W | Access byte address |
| req_be | input | 4 | Byte-enable mask relative to a 32-bit word |
| req_write | input | 1 | 1 = write, 0 = read |
| cfg_width | input | 2 | Bus width code (00 8-bit, 01 16-bit, 10 32-bit, 11 reserved) |
| cfg_byte_write | input | 1 | 1 = per-lane write strobes, 0 = common enable with byte selects |
| bus_addr | output | ADDR_W | Address held for the external access |
| cs_n | output | 1 | Chip select, active low |
| rd_n | output | 1 | Read strobe, active low |
| we_n | output | 1 | Common write enable, active low |
| wr_n | output | 4 | Per-lane write strobes, active low |
| bs_n | output | 4 | Byte selects, active low |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle pulse on a reserved width code |

## Verification
A vector table sweeps the three bus widths against both lane schemes and both directions. It tells the per-lane strobes apart from the common enable with byte selects, and reads that carry lane qualification from reads that do not. Each address offset and byte-enable pattern is chosen so that a wrong half-word or byte pick on the narrower buses, or a leak onto lanes 2 and 3, changes a visible pin. An empty mask shows that the chip-select cycle still runs without a write strobe. Directed cases cover the reserved code, restarts and input changes while busy, and reset in mid-access.

// File: rtl/lsg_pkg.sv
package lsg_pkg;

    localparam int LANES     = 4;
    localparam int SETUP_CYC = 1;
    localparam int PULSE_CYC = 2;
    localparam int HOLD_CYC  = 1;
    localparam int PH_MAX    = (PULSE_CYC > SETUP_CYC) ?
                               ((PULSE_CYC > HOLD_CYC) ? PULSE_CYC : HOLD_CYC) :
                               ((SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC);
    localparam int CNT_W     = $clog2(PH_MAX + 1);

    typedef enum logic [1:0] {
        BW_8    = 2'b00,
        BW_16   = 2'b01,
        BW_32   = 2'b10,
        BW_RSVD = 2'b11
    } bus_width_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_PULSE,
        PH_HOLD,
        PH_DONE
    } phase_e;

    typedef struct packed {
        logic             write;
        logic             byte_write;
        bus_width_e       width;
        logic [LANES-1:0] lanes;
    } acc_t;

    function automatic logic wide_bus(bus_width_e w);
        return (w == BW_16) || (w == BW_32);
    endfunction

    function automatic int lane_count(bus_width_e w);
        case (w)
            BW_8:    return 1;
            BW_16:   return 2;
            BW_32:   return 4;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/lsg_lane_map.sv
module lsg_lane_map
    import lsg_pkg::*;
(
    input  bus_width_e       width,
    input  logic [1:0]       addr_lo,
    input  logic [LANES-1:0] be,
    output logic [LANES-1:0] lanes
);

    localparam int HALF = LANES / 2;

    logic [HALF-1:0] half_sel;

    assign half_sel = addr_lo[1] ? be[LANES-1:HALF] : be[HALF-1:0];

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_comb begin
            case (width)
                BW_32:   lanes[i] = be[i];
                BW_16:   lanes[i] = (i < HALF) ? half_sel[i % HALF] : 1'b0;
                BW_8:    lanes[i] = (i == 0) ? be[addr_lo] : 1'b0;
                default: lanes[i] = 1'b0;
            endcase
        end
    end

    // R5: never more active lanes than the bus carries
    always_comb begin
        a_r5_lane_count: assert ($countones(lanes) <= lane_count(width));
    end

endmodule

// File: rtl/lsg_sequencer.sv
module lsg_sequencer
    import lsg_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [1:0]        cfg_width,
    input  logic              cfg_byte_write,
    input  logic [LANES-1:0]  lanes,
    output phase_e            phase,
    output acc_t              acc,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              busy,
    output logic              done,
    output logic              err
);

    logic [CNT_W-1:0] cnt;
    bus_width_e       width_in;

    assign width_in = bus_width_e'(cfg_width);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            cnt      <= '0;
            acc      <= '0;
            bus_addr <= '0;
            err      <= 1'b0;
        end else begin
            err <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        if (width_in == BW_RSVD) begin
                            err <= 1'b1;
                        end else begin
                            phase    <= PH_SETUP;
                            cnt      <= CNT_W'(SETUP_CYC - 1);
                            acc      <= '{write: req_write, byte_write: cfg_byte_write,
                                          width: width_in, lanes: lanes};
                            bus_addr <= req_addr;
                        end
                    end
                end
                PH_SETUP: begin
                    if (cnt == '0) begin
                        phase <= PH_PULSE;
                        cnt   <= CNT_W'(PULSE_CYC - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_PULSE: begin
                    if (cnt == '0) begin
                        phase <= PH_HOLD;
                        cnt   <= CNT_W'(HOLD_CYC - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_HOLD: begin
                    if (cnt == '0) begin
                        phase <= PH_DONE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_DONE: phase <= PH_IDLE;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign busy = (phase != PH_IDLE);
    assign done = (phase == PH_DONE);

    // R4: reserved code never opens an access
    a_r4_rsvd_blocked: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE && start && cfg_width == 2'b11) |=> (phase == PH_IDLE && err));

    // R12: latched request stays frozen while the access runs
    a_r12_request_frozen: assert property (@(posedge clk) disable iff (rst)
        (busy && phase != PH_DONE) |=> ($stable(acc) && $stable(bus_addr)));

    // R3: done is a single pulse that ends the busy period
    a_r3_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));

    // R2: pulse phase lasts at least two cycles
    a_r2_pulse_len: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SETUP) |=> (phase == PH_PULSE) ##1 (phase == PH_PULSE));

endmodule

// File: rtl/lsg_strobe_drv.sv
module lsg_strobe_drv
    import lsg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  phase_e           phase,
    input  acc_t             acc,
    output logic             cs_n,
    output logic             rd_n,
    output logic             we_n,
    output logic [LANES-1:0] wr_n,
    output logic [LANES-1:0] bs_n
);

    logic window;
    logic strobe;
    logic wide;
    logic any_lane;

    assign window   = (phase == PH_SETUP) || (phase == PH_PULSE) || (phase == PH_HOLD);
    assign strobe   = (phase == PH_PULSE);
    assign wide     = wide_bus(acc.width);
    assign any_lane = |acc.lanes;

    assign cs_n = !window;
    assign rd_n = !(strobe && !acc.write);
    assign we_n = !(strobe && acc.write && any_lane && (!wide || !acc.byte_write));

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign wr_n[i] = !(strobe && acc.write && wide && acc.byte_write && acc.lanes[i]);
        assign bs_n[i] = !(window && wide && !acc.byte_write && acc.lanes[i]);
    end

    // R2: no strobe outside the chip-select window
    a_r2_strobes_in_cs: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> (rd_n && we_n && (&wr_n) && (&bs_n)));

    // R7: per-lane scheme reads carry no lane qualification
    a_r7_plain_read: assert property (@(posedge clk) disable iff (rst)
        (!rd_n && acc.byte_write) |-> ((&wr_n) && (&bs_n) && we_n));

    // R10: narrow bus uses neither lane strobes nor byte selects
    a_r10_narrow_bus: assert property (@(posedge clk) disable iff (rst)
        (acc.width == BW_8) |-> ((&wr_n) && (&bs_n)));

    // R11: upper lanes idle on a half-width bus
    a_r11_upper_idle: assert property (@(posedge clk) disable iff (rst)
        (acc.width == BW_16) |-> (wr_n[3:2] == 2'b11 && bs_n[3:2] == 2'b11));

endmodule

// File: rtl/lane_strobe_gen.sv
module lane_strobe_gen
    import lsg_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [3:0]        req_be,
    input  logic              req_write,
    input  logic [1:0]        cfg_width,
    input  logic              cfg_byte_write,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              cs_n,
    output logic              rd_n,
    output logic              we_n,
    output logic [3:0]        wr_n,
    output logic [3:0]        bs_n,
    output logic              busy,
    output logic              done,
    output logic              err
);

    logic [LANES-1:0] lanes;
    phase_e           phase;
    acc_t             acc;

    lsg_lane_map u_map (
        .width   (bus_width_e'(cfg_width)),
        .addr_lo (req_addr[1:0]),
        .be      (req_be),
        .lanes   (lanes)
    );

    lsg_sequencer #(.ADDR_W(ADDR_W)) u_seq (
        .clk            (clk),
        .rst            (rst),
        .start          (start),
        .req_addr       (req_addr),
        .req_write      (req_write),
        .cfg_width      (cfg_width),
        .cfg_byte_write (cfg_byte_write),
        .lanes          (lanes),
        .phase          (phase),
        .acc            (acc),
        .bus_addr       (bus_addr),
        .busy           (busy),
        .done           (done),
        .err            (err)
    );

    lsg_strobe_drv u_drv (
        .clk   (clk),
        .rst   (rst),
        .phase (phase),
        .acc   (acc),
        .cs_n  (cs_n),
        .rd_n  (rd_n),
        .we_n  (we_n),
        .wr_n  (wr_n),
        .bs_n  (bs_n)
    );

    // R1: reset leaves every strobe high on the next cycle
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (cs_n && rd_n && we_n && (&wr_n) && (&bs_n) && !busy && !err));

endmodule

// File: tb/sim_lane_strobe_gen.sv
`timescale 1ns/1ps
module sim_lane_strobe_gen;

    localparam int AW = 24;

    logic          clk = 1'b0;
    logic          rst;
    logic          start;
    logic [AW-1:0] req_addr;
    logic [3:0]    req_be;
    logic          req_write;
    logic [1:0]    cfg_width;
    logic          cfg_byte_write;
    logic [AW-1:0] bus_addr;
    logic          cs_n, rd_n, we_n, busy, done, err;
    logic [3:0]    wr_n, bs_n;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    lane_strobe_gen #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst(rst), .start(start), .req_addr(req_addr), .req_be(req_be),
        .req_write(req_write), .cfg_width(cfg_width), .cfg_byte_write(cfg_byte_write),
        .bus_addr(bus_addr), .cs_n(cs_n), .rd_n(rd_n), .we_n(we_n), .wr_n(wr_n),
        .bs_n(bs_n), .busy(busy), .done(done), .err(err)
    );

    // {width[13:12], byte_write[11], write[10], addr_lo[9:8], be[7:4], expected lanes[3:0]}
    localparam int NV = 12;
    localparam logic [13:0] VECS [NV] = '{
        {2'b10, 1'b1, 1'b1, 2'd0, 4'b1011, 4'b1011},
        {2'b10, 1'b0, 1'b1, 2'd0, 4'b0110, 4'b0110},
        {2'b10, 1'b0, 1'b0, 2'd0, 4'b1111, 4'b1111},
        {2'b10, 1'b1, 1'b0, 2'd0, 4'b0101, 4'b0101},
        {2'b01, 1'b1, 1'b1, 2'd2, 4'b1100, 4'b0011},
        {2'b01, 1'b0, 1'b1, 2'd0, 4'b1110, 4'b0010},
        {2'b01, 1'b0, 1'b0, 2'd2, 4'b0100, 4'b0001},
        {2'b00, 1'b1, 1'b1, 2'd3, 4'b1000, 4'b0001},
        {2'b00, 1'b0, 1'b1, 2'd1, 4'b0001, 4'b0000},
        {2'b00, 1'b0, 1'b0, 2'd2, 4'b0100, 4'b0001},
        {2'b10, 1'b1, 1'b1, 2'd0, 4'b0000, 4'b0000},
        {2'b01, 1'b1, 1'b0, 2'd0, 4'b0011, 4'b0011}
    };

    function automatic logic [14:0] pins_now();
        return {cs_n, rd_n, we_n, wr_n, bs_n, done, busy};
    endfunction

    // expected {cs_n, rd_n, we_n, wr_n, bs_n, done, busy} in cycle k after start
    function automatic logic [14:0] pins_exp(logic [1:0] w, logic bw, logic wr,
                                             logic [3:0] mk, int k);
        logic win, stb, wide;
        logic e_cs, e_rd, e_we;
        logic [3:0] e_wr, e_bs;
        win  = (k >= 1 && k <= 4);
        stb  = (k == 2 || k == 3);
        wide = (w != 2'b00);
        e_cs = !win;
        e_rd = !(stb && !wr);
        e_we = !(stb && wr && (mk != 4'b0) && (!wide || !bw));
        for (int i = 0; i < 4; i++) begin
            e_wr[i] = !(stb && wr && wide && bw && mk[i]);
            e_bs[i] = !(win && wide && !bw && mk[i]);
        end
        return {e_cs, e_rd, e_we, e_wr, e_bs, (k == 5), (k >= 1 && k <= 5)};
    endfunction

    task automatic check(input logic ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        start = 1'b0; req_addr = '0; req_be = '0; req_write = 1'b0;
        cfg_width = 2'b10; cfg_byte_write = 1'b0;
    endtask

    task automatic check_idle(input string tag);
        check(pins_now() == 15'b111_1111_1111_0_0 && !err, tag, "idle pins",
              {16'b0, pins_now(), err}, {16'b0, 15'b111_1111_1111_0_0, 1'b0});
    endtask

    initial begin
        #(5.0 * 100000);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1;
        idle_inputs();
        repeat (3) @(negedge clk);
        check_idle("R1");
        rst = 1'b0;
        @(negedge clk);
        check_idle("R1");

        // vector table: widths x schemes x directions
        for (int vi = 0; vi < NV; vi++) begin
            logic [13:0]   v;
            logic [AW-1:0] a;
            string         tag;
            v = VECS[vi];
            a = {22'h3A5C1 ^ 22'(vi * 7), v[9:8]};
            if (v[3:0] == 4'b0 && v[10])      tag = "R13";
            else if (v[13:12] == 2'b00)       tag = "R10";
            else if (v[13:12] == 2'b01)       tag = "R11";
            else if (v[11] && v[10])          tag = "R6";
            else if (v[11])                   tag = "R7";
            else if (v[10])                   tag = "R8";
            else                              tag = "R9";
            cfg_width = v[13:12]; cfg_byte_write = v[11]; req_write = v[10];
            req_addr = a; req_be = v[7:4]; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            for (int k = 1; k <= 6; k++) begin
                logic [14:0] e;
                e = pins_exp(v[13:12], v[11], v[10], v[3:0], k);
                check(pins_now() == e, tag,
                      $sformatf("R2/R3/R5 vec%0d cycle%0d pins", vi, k),
                      {17'b0, pins_now()}, {17'b0, e});
                if (k <= 4)
                    check(bus_addr == a, "R12", $sformatf("vec%0d cycle%0d addr", vi, k),
                          32'(bus_addr), 32'(a));
                if (k < 6) @(negedge clk);
            end
        end

        // R4: reserved width code
        cfg_width = 2'b11; req_write = 1'b1; req_be = 4'hF; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(err && cs_n && !busy, "R4", "reserved err pulse",
              {29'b0, err, cs_n, busy}, {29'b0, 3'b110});
        @(negedge clk);
        check(!err && cs_n && !busy && rd_n && we_n, "R4", "reserved no access",
              {27'b0, err, cs_n, busy, rd_n, we_n}, {27'b0, 5'b01011});

        // R3 / R12: restart and input changes while busy are ignored
        cfg_width = 2'b10; cfg_byte_write = 1'b0; req_write = 1'b1;
        req_addr = 24'h00A5A4; req_be = 4'hF; start = 1'b1;
        @(negedge clk);
        req_addr = 24'h005A5B; req_be = 4'b0001; req_write = 1'b0;
        cfg_width = 2'b01; cfg_byte_write = 1'b1;
        @(negedge clk);
        check(!we_n && rd_n && bs_n == 4'b0000 && wr_n == 4'hF, "R12", "frozen pulse pins",
              {22'b0, we_n, rd_n, bs_n, wr_n}, {22'b0, 2'b01, 4'b0000, 4'b1111});
        @(negedge clk);
        @(negedge clk);
        check(bus_addr == 24'h00A5A4 && !cs_n, "R12", "frozen addr in hold",
              32'(bus_addr), 32'h00A5A4);
        @(negedge clk);
        check(done && cs_n, "R3", "done after window", {30'b0, done, cs_n}, 32'b11);
        start = 1'b0;
        @(negedge clk);
        check(!done && !busy && cs_n, "R3", "no restart from busy start",
              {29'b0, done, busy, cs_n}, 32'b001);
        @(negedge clk);
        check(cs_n && !busy, "R3", "still idle", {30'b0, cs_n, busy}, 32'b10);

        // R1: reset in the middle of an access
        cfg_width = 2'b10; cfg_byte_write = 1'b1; req_write = 1'b1; req_be = 4'hF;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check_idle("R1");
        rst = 1'b0;
        @(negedge clk);
        check_idle("R1");

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule